// File: doc/BRIEF.md
# Single-Bank SDRAM Command Timing Tracker

This block follows one bank of a DDR3-class SDRAM and tells a command scheduler, cycle by cycle, which commands that bank can legally take next. It keeps down-counters for the active-time, read-to-precharge, read-to-write, read-to-read and precharge-recovery windows. From these and a small amount of bank state (open or closed, auto precharge pending), it raises one permission flag for each command kind. A request that arrives while its flag is low is dropped, and a sticky violation flag goes high.

A read that carries the auto precharge bit does not close the bank at once. The tracker models the hidden precharge as starting at the later of two points: the read-to-precharge window (additive latency plus read-to-precharge time, never less than four clocks) and the end of the minimum active time counted from the activate. A one-cycle `apStart` pulse marks that point, and the recovery window before the next activate is counted from it. The timing values arrive as pins, in cycles, and are captured while reset is held.

Top module: `bankPrechargeTracker`

## Requirements
- R1: After reset the bank is closed and recovered: `actOk`, `preOk` and `bankIdle` are 1; `rdOk`, `wrOk`, `apStart` and `violation` are 0.
- R2: Once an activate is accepted in cycle a, and no read follows it, `preOk` is first 1 in cycle a+RAS.
- R3: Once a read is accepted in cycle c, `rdOk` is low until cycle c+CCD, when it is high again. A burst is never cut short by a second read.
- R4: Once a read is accepted in cycle c, `wrOk` is first 1 in cycle c+max(1, RL+CCD+2−WL).
- R5: For a read accepted in cycle c, the read-to-precharge distance is S = max(4, AL+RTP). `preOk` is not 1 before cycle c+S, and it is not 1 before cycle a+RAS either.
- R6: A read with `autoPre`=1 accepted in cycle c, on a bank activated in cycle a, makes `apStart` pulse for exactly one cycle, in cycle max(c+S, a+RAS). From the read until that pulse, `rdOk`, `wrOk` and `preOk` are 0. After the pulse the bank is closed.
- R7: When a precharge starts in cycle p, whether explicit or internal, `actOk` is first 1 in cycle p+RP. A precharge may be issued to a bank that is already closed, and the recovery window then restarts from the latest one.
- R8: A request made while the flag for its kind is 0 gives `cmdAccepted`=0 and changes no timing. `violation` goes to 1 the next cycle and stays 1 until reset.
- R9: An activate is permitted only while the bank is closed. Reads and writes are permitted only while it is open. `actOk` and `rdOk` are never 1 together.
- R10: The timing pins (each 1 to 63) are sampled only while `rst_n` is low. Changes after reset have no effect on any window.
- R11: Command codes on `cmdType` are 0 = none, 1 = activate, 2 = read, 3 = write, 4 = precharge. `autoPre` is used only with a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; timing pins are sampled while low |
| cfgAl | input | 6 | Additive latency, cycles |
| cfgRl | input | 6 | Read latency, cycles |
| cfgWl | input | 6 | Write latency, cycles |
| cfgCcd | input | 6 | Read-to-read spacing, cycles |
| cfgRtp | input | 6 | Read-to-precharge time, cycles |
| cfgRas | input | 6 | Minimum active time, cycles |
| cfgRp | input | 6 | Precharge recovery time, cycles |
| cmdValid | input | 1 | A command is requested this cycle |
| cmdType | input | 3 | Command code (see R11) |
| autoPre | input | 1 | Auto precharge bit for a read |
| actOk | output | 1 | Activate permitted now |
| rdOk | output | 1 | Read permitted now |
| wrOk | output | 1 | Write permitted now |
| preOk | output | 1 | Precharge permitted now |
| cmdAccepted | output | 1 | The current request is taken |
| apStart | output | 1 | Internal auto precharge starts this cycle |
| bankIdle | output | 1 | Bank closed and recovery window elapsed |
| violation | output | 1 | Sticky: an illegal request was seen |

## Verification
The bench builds the tracker with its default 6-bit timing width. It then sweeps 288 runtime configurations that combine AL {1,2}, RL {3,6}, WL {2,7}, CCD {1,4}, RTP {1,3,5}, RAS {1,6,12} and RP {1,3}. These ranges cover three cases. In the first, the four-clock floor sets the read-to-precharge distance. In the second, a long RAS pushes the internal precharge past that distance. In the third, WL is larger than RL+CCD+2, so the read-to-write gap is clamped to one cycle. Each configuration is followed by garbage on the timing pins, which shows whether the sampled values are held.

// File: rtl/bankTimingPkg.sv
package bankTimingPkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmdKind_e;

  // counter slots shared by control and datapath
  localparam int SLOT_RAS  = 0;
  localparam int SLOT_RTP  = 1;
  localparam int SLOT_RDWR = 2;
  localparam int SLOT_CCD  = 3;
  localparam int SLOT_RP   = 4;
  localparam int NUM_SLOTS = 5;

  // strobes from control to datapath: one load request per counter
  typedef struct packed {
    logic ldRp;
    logic ldCcd;
    logic ldRdWr;
    logic ldRtp;
    logic ldRas;
  } loadStrobes_t;

endpackage

// File: rtl/bankDownCounter.sv
module bankDownCounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         done
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (load)            count <= loadVal;
    else if (count != '0)     count <= count - W'(1);
  end

  assign done = (count == '0);
endmodule

// File: rtl/bankTimingDatapath.sv
module bankTimingDatapath
  import bankTimingPkg::*;
#(
  parameter int TW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        cfgAl,
  input  logic [TW-1:0]        cfgRl,
  input  logic [TW-1:0]        cfgWl,
  input  logic [TW-1:0]        cfgCcd,
  input  logic [TW-1:0]        cfgRtp,
  input  logic [TW-1:0]        cfgRas,
  input  logic [TW-1:0]        cfgRp,
  input  loadStrobes_t         strobes,
  output logic [NUM_SLOTS-1:0] slotDone
);
  localparam int CW = TW + 2;

  logic [TW-1:0] alQ, rlQ, wlQ, ccdQ, rtpQ, rasQ, rpQ;

  // timing values are sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alQ  <= cfgAl;
      rlQ  <= cfgRl;
      wlQ  <= cfgWl;
      ccdQ <= cfgCcd;
      rtpQ <= cfgRtp;
      rasQ <= cfgRas;
      rpQ  <= cfgRp;
    end
  end

  logic [CW-1:0] rtpSpan, rtpEff, rwSum;
  logic [CW-1:0] loadVals [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] loadEns;

  always_comb begin
    rtpSpan = CW'(alQ) + CW'(rtpQ);
    rtpEff  = (rtpSpan < CW'(4)) ? CW'(4) : rtpSpan;
    rwSum   = CW'(rlQ) + CW'(ccdQ) + CW'(2);
    // a counter loaded with N-1 in cycle c reaches zero in cycle c+N
    loadVals[SLOT_RAS]  = CW'(rasQ) - CW'(1);
    loadVals[SLOT_RTP]  = rtpEff - CW'(1);
    loadVals[SLOT_RDWR] = (rwSum > CW'(wlQ)) ? (rwSum - CW'(wlQ) - CW'(1)) : '0;
    loadVals[SLOT_CCD]  = CW'(ccdQ) - CW'(1);
    loadVals[SLOT_RP]   = CW'(rpQ) - CW'(1);
    loadEns[SLOT_RAS]   = strobes.ldRas;
    loadEns[SLOT_RTP]   = strobes.ldRtp;
    loadEns[SLOT_RDWR]  = strobes.ldRdWr;
    loadEns[SLOT_CCD]   = strobes.ldCcd;
    loadEns[SLOT_RP]    = strobes.ldRp;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    bankDownCounter #(.W(CW)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (loadEns[i]),
      .loadVal(loadVals[i]),
      .done   (slotDone[i])
    );
  end
endmodule

// File: rtl/bankTimingControl.sv
module bankTimingControl
  import bankTimingPkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdType,
  input  logic                 autoPre,
  input  logic [NUM_SLOTS-1:0] slotDone,
  output loadStrobes_t         strobes,
  output logic                 actOk,
  output logic                 rdOk,
  output logic                 wrOk,
  output logic                 preOk,
  output logic                 cmdAccepted,
  output logic                 apStart,
  output logic                 bankIdle,
  output logic                 violation
);
  logic bankOpen, apPending, violationQ;
  logic reqOk, takeAct, takeRd, takeWr, takePre;
  logic closeWindowsDone;

  assign closeWindowsDone = slotDone[SLOT_RTP] && slotDone[SLOT_RAS];

  assign actOk   = !bankOpen && !apPending && slotDone[SLOT_RP];
  assign rdOk    = bankOpen && !apPending && slotDone[SLOT_CCD];
  assign wrOk    = bankOpen && !apPending && slotDone[SLOT_RDWR];
  assign preOk   = !apPending && closeWindowsDone;
  assign apStart = apPending && closeWindowsDone;
  assign bankIdle = !bankOpen && slotDone[SLOT_RP];

  always_comb begin
    case (cmdType)
      CMD_NONE: reqOk = 1'b1;
      CMD_ACT:  reqOk = actOk;
      CMD_RD:   reqOk = rdOk;
      CMD_WR:   reqOk = wrOk;
      CMD_PRE:  reqOk = preOk;
      default:  reqOk = 1'b0;
    endcase
  end

  assign cmdAccepted = cmdValid && reqOk;
  assign takeAct = cmdAccepted && (cmdType == CMD_ACT);
  assign takeRd  = cmdAccepted && (cmdType == CMD_RD);
  assign takeWr  = cmdAccepted && (cmdType == CMD_WR);
  assign takePre = cmdAccepted && (cmdType == CMD_PRE);

  always_comb begin
    strobes        = '0;
    strobes.ldRas  = takeAct;
    strobes.ldRtp  = takeRd;
    strobes.ldRdWr = takeRd;
    strobes.ldCcd  = takeRd;
    strobes.ldRp   = takePre || apStart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bankOpen   <= 1'b0;
      apPending  <= 1'b0;
      violationQ <= 1'b0;
    end else begin
      if (takeAct) bankOpen <= 1'b1;
      if (takePre || apStart) bankOpen <= 1'b0;
      if (takeRd && autoPre) apPending <= 1'b1;
      else if (apStart) apPending <= 1'b0;
      if (cmdValid && !reqOk) violationQ <= 1'b1;
    end
  end

  assign violation = violationQ;

  // writes carry no window of their own in this tracker
  logic unusedWr;
  assign unusedWr = takeWr;
endmodule

// File: rtl/bankPrechargeTracker.sv
module bankPrechargeTracker
  import bankTimingPkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfgAl,
  input  logic [TW-1:0] cfgRl,
  input  logic [TW-1:0] cfgWl,
  input  logic [TW-1:0] cfgCcd,
  input  logic [TW-1:0] cfgRtp,
  input  logic [TW-1:0] cfgRas,
  input  logic [TW-1:0] cfgRp,
  input  logic          cmdValid,
  input  logic [2:0]    cmdType,
  input  logic          autoPre,
  output logic          actOk,
  output logic          rdOk,
  output logic          wrOk,
  output logic          preOk,
  output logic          cmdAccepted,
  output logic          apStart,
  output logic          bankIdle,
  output logic          violation
);
  loadStrobes_t         strobes;
  logic [NUM_SLOTS-1:0] slotDone;

  bankTimingControl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdType(cmdType), .autoPre(autoPre),
    .slotDone(slotDone), .strobes(strobes),
    .actOk(actOk), .rdOk(rdOk), .wrOk(wrOk), .preOk(preOk),
    .cmdAccepted(cmdAccepted), .apStart(apStart),
    .bankIdle(bankIdle), .violation(violation)
  );

  bankTimingDatapath #(.TW(TW)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .cfgAl(cfgAl), .cfgRl(cfgRl), .cfgWl(cfgWl), .cfgCcd(cfgCcd),
    .cfgRtp(cfgRtp), .cfgRas(cfgRas), .cfgRp(cfgRp),
    .strobes(strobes), .slotDone(slotDone)
  );
endmodule

// File: rtl/bankTrackerChecker.sv
module bankTrackerChecker
  import bankTimingPkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmdAccepted,
  input logic [2:0] cmdType,
  input logic       actOk,
  input logic       rdOk,
  input logic       wrOk,
  input logic       preOk,
  input logic       apStart,
  input logic       violation
);
  // R8
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R9
  open_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    actOk |-> (!rdOk && !wrOk));

  // R5
  read_pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdAccepted && cmdType == CMD_RD) |=> !preOk);

  // R6
  ap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apStart |=> (!apStart && !rdOk && !wrOk));

  // R2
  act_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdAccepted && cmdType == CMD_ACT) |=> !actOk);
endmodule

bind bankPrechargeTracker bankTrackerChecker chk_i (
  .clk(clk), .rst_n(rst_n), .cmdAccepted(cmdAccepted), .cmdType(cmdType),
  .actOk(actOk), .rdOk(rdOk), .wrOk(wrOk), .preOk(preOk),
  .apStart(apStart), .violation(violation)
);

// File: tb/bankPrechargeTracker_tb_top.sv
`timescale 1ns/1ps
module bankPrechargeTracker_tb_top;
  import bankTimingPkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfgAl = 6'd1, cfgRl = 6'd1, cfgWl = 6'd1, cfgCcd = 6'd1;
  logic [5:0] cfgRtp = 6'd1, cfgRas = 6'd1, cfgRp = 6'd1;
  logic cmdValid = 1'b0;
  logic [2:0] cmdType = 3'd0;
  logic autoPre = 1'b0;
  logic actOk, rdOk, wrOk, preOk, cmdAccepted, apStart, bankIdle, violation;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bankPrechargeTracker #(.TW(6)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfgAl(cfgAl), .cfgRl(cfgRl), .cfgWl(cfgWl), .cfgCcd(cfgCcd),
    .cfgRtp(cfgRtp), .cfgRas(cfgRas), .cfgRp(cfgRp),
    .cmdValid(cmdValid), .cmdType(cmdType), .autoPre(autoPre),
    .actOk(actOk), .rdOk(rdOk), .wrOk(wrOk), .preOk(preOk),
    .cmdAccepted(cmdAccepted), .apStart(apStart),
    .bankIdle(bankIdle), .violation(violation)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic applyReset(input int al, rl, wl, ccd, rtp, ras, rp);
    @(negedge clk);
    rst_n = 1'b0;
    cfgAl = 6'(al); cfgRl = 6'(rl); cfgWl = 6'(wl); cfgCcd = 6'(ccd);
    cfgRtp = 6'(rtp); cfgRas = 6'(ras); cfgRp = 6'(rp);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: garbage after reset must not change any window
    cfgAl = 6'd63; cfgRl = 6'd63; cfgWl = 6'd63; cfgCcd = 6'd63;
    cfgRtp = 6'd63; cfgRas = 6'd63; cfgRp = 6'd63;
  endtask

  // R11 codes: 1 act, 2 read, 3 write, 4 precharge
  task automatic issue(input cmdKind_e kind, input logic ap, output int acc);
    @(negedge clk);
    cmdValid = 1'b1; cmdType = kind; autoPre = ap;
    #1 acc = int'(cmdAccepted);
    @(posedge clk);
    #1 cmdValid = 1'b0; cmdType = CMD_NONE; autoPre = 1'b0;
  endtask

  task automatic watch(input int kFrom, input int lim,
                       output int gRd, output int gWr, output int gPre,
                       output int gAp, output int gAct);
    gRd = 0; gWr = 0; gPre = 0; gAp = 0; gAct = 0;
    for (int k = kFrom; k <= lim; k++) begin
      @(negedge clk);
      if (rdOk && gRd == 0)    gRd = k;
      if (wrOk && gWr == 0)    gWr = k;
      if (preOk && gPre == 0)  gPre = k;
      if (apStart && gAp == 0) gAp = k;
      if (actOk && gAct == 0)  gAct = k;
    end
  endtask

  task automatic runConfig(input int al, rl, wl, ccd, rtp, ras, rp);
    int acc, gRd, gWr, gPre, gAp, gAct;
    int sEff, eWr, ePre, eAp;
    sEff = imax(4, al + rtp);
    eWr  = imax(1, rl + ccd + 2 - wl);
    ePre = imax(sEff, ras - 1);
    eAp  = ePre;

    applyReset(al, rl, wl, ccd, rtp, ras, rp);
    @(negedge clk);
    // R1
    chk("R1 actOk", int'(actOk), 1);
    chk("R1 rdOk/wrOk", int'(rdOk | wrOk), 0);
    chk("R1 preOk", int'(preOk), 1);
    chk("R1 bankIdle", int'(bankIdle), 1);
    chk("R1 violation/apStart", int'(violation | apStart), 0);

    // open, then read one cycle later
    issue(CMD_ACT, 1'b0, acc);
    chk("R9 act on closed bank", acc, 1);
    issue(CMD_RD, 1'b0, acc);
    chk("R9 read on open bank", acc, 1);
    watch(1, imax(imax(ccd, eWr), ePre) + 1, gRd, gWr, gPre, gAp, gAct);
    chk("R3 read-to-read gap (R10)", gRd, ccd);
    chk("R4 read-to-write gap (R10)", gWr, eWr);
    chk("R5 read-to-precharge gap (R10)", gPre, ePre);
    chk("R9 no activate while open", gAct, 0);

    // precharge twice; recovery counted from the second
    issue(CMD_PRE, 1'b0, acc);
    chk("R7 first precharge", acc, 1);
    issue(CMD_PRE, 1'b0, acc);
    chk("R7 precharge after precharge", acc, 1);
    watch(1, rp + 1, gRd, gWr, gPre, gAp, gAct);
    chk("R7 precharge-to-activate gap", gAct, rp);

    // read with auto precharge plus an illegal read while it is pending
    issue(CMD_ACT, 1'b0, acc);
    chk("R9 reopen", acc, 1);
    chk("R8 violation clear before illegal request", int'(violation), 0);
    issue(CMD_RD, 1'b1, acc);
    chk("R6 read with auto precharge", acc, 1);
    issue(CMD_RD, 1'b0, acc);
    chk("R8 illegal read dropped", acc, 0);
    watch(2, eAp + rp + 1, gRd, gWr, gPre, gAp, gAct);
    chk("R6 internal precharge start", gAp, eAp);
    chk("R6 no read while pending", gRd, 0);
    chk("R7 activate after internal precharge", gAct, eAp + rp);
    chk("R8 violation set", int'(violation), 1);

    // plain activate then precharge: active-time window alone
    issue(CMD_ACT, 1'b0, acc);
    chk("R2 activate", acc, 1);
    watch(1, ras + 1, gRd, gWr, gPre, gAp, gAct);
    chk("R2 activate-to-precharge gap", gPre, ras);
    issue(CMD_PRE, 1'b0, acc);
    chk("R2 precharge taken", acc, 1);
    @(negedge clk);
    chk("R8 violation sticky", int'(violation), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (cfgAl[i]) begin end
    for (int al = 1; al <= 2; al++)
      for (int rlI = 0; rlI < 2; rlI++)
        for (int wlI = 0; wlI < 2; wlI++)
          for (int ccdI = 0; ccdI < 2; ccdI++)
            for (int rtpI = 0; rtpI < 3; rtpI++)
              for (int rasI = 0; rasI < 3; rasI++)
                for (int rpI = 0; rpI < 2; rpI++)
                  runConfig(al,
                            (rlI == 0) ? 3 : 6,
                            (wlI == 0) ? 2 : 7,
                            (ccdI == 0) ? 1 : 4,
                            1 + 2 * rtpI,
                            (rasI == 0) ? 1 : ((rasI == 1) ? 6 : 12),
                            (rpI == 0) ? 1 : 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule